// File: doc/BRIEF.md
# Forward-Only Accumulator Processor Core

This block is a compact 32-bit accumulator machine that runs short handler routines held in one word-addressed memory shared by code and data. Its state is an accumulator, two operand registers (a and b) and an instruction pointer. A one-cycle start pulse, given while the core is idle, supplies the entry address. The core then fetches and executes instructions until it meets a halt instruction or a fault.

Every branch offset is an unsigned count of at least one, so the instruction pointer only ever grows. Each run therefore ends within a bounded number of steps without any preemption. A run ends with a one-cycle done pulse, and a fault flag tells whether the run ended cleanly. The accumulator and the operand registers keep their values from one run to the next. Only reset clears them.

The memory sits outside the core behind a single port. A read returns its data in the cycle after the address is presented. A write takes effect at the clock edge. Each instruction word holds an 8-bit opcode in bits 31:24 and a 24-bit immediate or offset in bits 23:0.

Top module: `fop_core`

## Requirements
- R1: While reset is held and afterwards while idle, busy, done, fault, mem_re and mem_we are all low.
- R2: A start pulse seen while idle makes busy high on the next cycle, with a fetch (mem_re high) at the entry address. A start pulse while busy has no effect on the run.
- R3: Read data is valid one cycle after mem_re. Each instruction takes a fetch cycle and an execute cycle. A load takes one more cycle. mem_re and mem_we are never high together.
- R4: 0x01 copies acc to a, 0x02 copies acc to b, and 0x03 exchanges a and b.
- R5: 0x04 loads the zero-extended 24-bit immediate into acc. 0x05 loads acc from word a[8:0]. 0x06 writes acc to word a[8:0].
- R6: With a as the second operand and acc as the destination: 0x10 AND, 0x11 OR, 0x16 add, 0x17 subtract, 0x18 multiply (low 32 bits), 0x19 unsigned divide. 0x12 inverts acc.
- R7: 0x13 shifts acc left, 0x14 shifts it right logically and 0x15 shifts it right arithmetically, by the full 32-bit value of a. An amount of 32 or more gives zero, or sign fill for 0x15.
- R8: 0x20 adds the unsigned offset in bits 23:0 to the instruction pointer. 0x21 does the same when a is zero and otherwise moves to the next word. The instruction pointer never decreases during a run.
- R9: A 0x20 or 0x21 instruction with offset zero ends the run with fault set, whatever the value of a.
- R10: An undefined opcode ends the run with fault set. A 0x19 with a equal to zero also ends the run with fault set and leaves acc unchanged.
- R11: Opcode 0x00 ends the run with fault clear. done is high for exactly one cycle, in the first cycle with busy low.
- R12: When the instruction pointer passes the last memory word, after a step or after a jump, the run ends with fault set and no access is made.
- R13: fault keeps its value while idle, and the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted when idle |
| entry | input | 9 | Word address of the first instruction |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when a run ends |
| fault | output | 1 | Last run ended on a fault |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | 9 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after mem_re |

## Verification
The first fetch must appear one cycle after start is sampled, at the entry address. Each store must appear in the execute cycle of its instruction. done must arrive exactly one cycle after the last busy cycle, which comes after two cycles per instruction, three per load, and one for an overrun fetch. An instruction-level reference model in the bench computes the expected busy length, the final fault value and the ordered list of stores for each run. The bench samples on every falling edge: it checks each write against the model's list as it appears, and it checks the busy length, done and fault in the cycle after busy drops and again one cycle later.

// File: rtl/fop_pkg.sv
package fop_pkg;
   localparam logic [7:0] OP_HALT = 8'h00;
   localparam logic [7:0] OP_MOVA = 8'h01;
   localparam logic [7:0] OP_MOVB = 8'h02;
   localparam logic [7:0] OP_SWAP = 8'h03;
   localparam logic [7:0] OP_LDI  = 8'h04;
   localparam logic [7:0] OP_LD   = 8'h05;
   localparam logic [7:0] OP_ST   = 8'h06;
   localparam logic [7:0] OP_AND  = 8'h10;
   localparam logic [7:0] OP_OR   = 8'h11;
   localparam logic [7:0] OP_NOT  = 8'h12;
   localparam logic [7:0] OP_SHL  = 8'h13;
   localparam logic [7:0] OP_SHR  = 8'h14;
   localparam logic [7:0] OP_SAR  = 8'h15;
   localparam logic [7:0] OP_ADD  = 8'h16;
   localparam logic [7:0] OP_SUB  = 8'h17;
   localparam logic [7:0] OP_MUL  = 8'h18;
   localparam logic [7:0] OP_DIV  = 8'h19;
   localparam logic [7:0] OP_JMP  = 8'h20;
   localparam logic [7:0] OP_JZ   = 8'h21;

   typedef enum logic [1:0] {S_IDLE, S_FETCH, S_EXEC, S_LOAD} fop_state_e;

   typedef struct packed {
      logic wr_acc;
      logic mov_a;
      logic mov_b;
      logic swap;
      logic load;
      logic store;
      logic jump;
      logic cond;
      logic halt;
      logic illegal;
      logic div;
   } fop_dec_t;
endpackage

// File: rtl/fop_decode.sv
module fop_decode
   import fop_pkg::*;
#(
   parameter int OP_W = 8
) (
   input  logic [OP_W-1:0] opcode,
   output fop_dec_t        dec
);
   generate
      if (OP_W != 8) begin : g_bad_opw
         $error("fop_decode: opcode table is 8 bits wide");
      end
   endgenerate

   always_comb begin
      dec = '0;
      case (opcode)
         OP_HALT: dec.halt   = 1'b1;
         OP_MOVA: dec.mov_a  = 1'b1;
         OP_MOVB: dec.mov_b  = 1'b1;
         OP_SWAP: dec.swap   = 1'b1;
         OP_LD:   dec.load   = 1'b1;
         OP_ST:   dec.store  = 1'b1;
         OP_LDI, OP_AND, OP_OR, OP_NOT, OP_SHL, OP_SHR,
         OP_SAR, OP_ADD, OP_SUB, OP_MUL: dec.wr_acc = 1'b1;
         OP_DIV: begin
            dec.wr_acc = 1'b1;
            dec.div    = 1'b1;
         end
         OP_JMP: dec.jump = 1'b1;
         OP_JZ: begin
            dec.jump = 1'b1;
            dec.cond = 1'b1;
         end
         default: dec.illegal = 1'b1;
      endcase
   end
endmodule

// File: rtl/fop_alu.sv
module fop_alu
   import fop_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int OP_W   = 8,
   localparam int IMM_W = DATA_W - OP_W
) (
   input  logic [OP_W-1:0]   opcode,
   input  logic [DATA_W-1:0] acc,
   input  logic [DATA_W-1:0] opa,
   input  logic [IMM_W-1:0]  imm,
   output logic [DATA_W-1:0] res,
   output logic              div_zero
);
   generate
      if (IMM_W < 1) begin : g_bad_imm
         $error("fop_alu: no room for an immediate field");
      end
   endgenerate

   assign div_zero = (opa == '0);

   always_comb begin
      case (opcode)
         OP_LDI:  res = DATA_W'(imm);
         OP_AND:  res = acc & opa;
         OP_OR:   res = acc | opa;
         OP_NOT:  res = ~acc;
         OP_SHL:  res = acc << opa;
         OP_SHR:  res = acc >> opa;
         OP_SAR:  res = $unsigned($signed(acc) >>> opa);
         OP_ADD:  res = acc + opa;
         OP_SUB:  res = acc - opa;
         OP_MUL:  res = acc * opa;
         OP_DIV:  res = div_zero ? acc : acc / opa;
         default: res = acc;
      endcase
   end
endmodule

// File: rtl/fop_core.sv
module fop_core
   import fop_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int OP_W   = 8,
   parameter int DEPTH  = 512,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int IMM_W  = DATA_W - OP_W,
   localparam int IP_W   = ADDR_W + 1,
   localparam int SUM_W  = IMM_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] entry,
   output logic              busy,
   output logic              done,
   output logic              fault,
   output logic              mem_re,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("fop_core: DEPTH must be at least 2");
      end
      if (IMM_W < IP_W) begin : g_bad_off
         $error("fop_core: offset field narrower than the pointer");
      end
      if (DATA_W < ADDR_W) begin : g_bad_data
         $error("fop_core: data narrower than an address");
      end
   endgenerate

   fop_state_e        st_q;
   logic [IP_W-1:0]   ip_q;
   logic [DATA_W-1:0] acc_q, a_q, b_q;
   logic              done_q, fault_q;

   logic [OP_W-1:0]   opcode;
   logic [IMM_W-1:0]  imm;
   fop_dec_t          dec;
   logic [DATA_W-1:0] alu_res;
   logic              div_zero;

   assign opcode = mem_rdata[DATA_W-1 -: OP_W];
   assign imm    = mem_rdata[IMM_W-1:0];

   fop_decode #(.OP_W(OP_W)) u_dec (
      .opcode (opcode),
      .dec    (dec)
   );

   fop_alu #(.DATA_W(DATA_W), .OP_W(OP_W)) u_alu (
      .opcode   (opcode),
      .acc      (acc_q),
      .opa      (a_q),
      .imm      (imm),
      .res      (alu_res),
      .div_zero (div_zero)
   );

   logic             in_fetch, in_exec;
   logic             take, bad, stop, overrun;
   logic [SUM_W-1:0] step, sum;
   logic [IP_W-1:0]  ip_nxt;

   assign in_fetch = (st_q == S_FETCH);
   assign in_exec  = (st_q == S_EXEC);
   assign take     = dec.jump && (!dec.cond || (a_q == '0));
   assign step     = take ? {1'b0, imm} : SUM_W'(1);
   assign sum      = SUM_W'(ip_q) + step;
   assign ip_nxt   = (sum >= SUM_W'(DEPTH)) ? IP_W'(DEPTH) : sum[IP_W-1:0];
   assign bad      = dec.illegal | (dec.jump & (imm == '0)) | (dec.div & div_zero);
   assign stop     = dec.halt | bad;
   assign overrun  = (ip_q >= IP_W'(DEPTH));

   assign mem_re    = (in_fetch && !overrun) || (in_exec && dec.load);
   assign mem_we    = in_exec && dec.store;
   assign mem_addr  = in_fetch ? ip_q[ADDR_W-1:0] : a_q[ADDR_W-1:0];
   assign mem_wdata = acc_q;
   assign busy      = (st_q != S_IDLE);
   assign done      = done_q;
   assign fault     = fault_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         ip_q    <= '0;
         acc_q   <= '0;
         a_q     <= '0;
         b_q     <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            S_IDLE: begin
               if (start) begin
                  st_q    <= S_FETCH;
                  ip_q    <= {1'b0, entry};
                  fault_q <= 1'b0;
               end
            end
            S_FETCH: begin
               if (overrun) begin
                  st_q    <= S_IDLE;
                  done_q  <= 1'b1;
                  fault_q <= 1'b1;
               end else begin
                  st_q <= S_EXEC;
               end
            end
            S_EXEC: begin
               if (stop) begin
                  st_q    <= S_IDLE;
                  done_q  <= 1'b1;
                  fault_q <= bad;
               end else begin
                  ip_q <= ip_nxt;
                  st_q <= dec.load ? S_LOAD : S_FETCH;
                  if (dec.wr_acc) acc_q <= alu_res;
                  if (dec.mov_a)  a_q   <= acc_q;
                  if (dec.mov_b)  b_q   <= acc_q;
                  if (dec.swap) begin
                     a_q <= b_q;
                     b_q <= a_q;
                  end
               end
            end
            S_LOAD: begin
               acc_q <= mem_rdata;
               st_q  <= S_FETCH;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_re && !mem_we)); // R1
   AST_ONE_PORT_USE: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_re && mem_we)); // R3
   AST_FORWARD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exec && !stop) |=> (ip_q > $past(ip_q))); // R8
   AST_DIV_ZERO_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
      (in_exec && dec.div && div_zero) |=> (fault && acc_q == $past(acc_q))); // R10
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11
   AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy))); // R11
   AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(fault)); // R13
endmodule

// File: tb/sim_fop_core.sv
module sim_fop_core;
   localparam int DEPTH = 512;

   logic        clk = 1'b0;
   logic        rst_n, start;
   logic [8:0]  entry_i;
   logic        busy, done, fault, mem_re, mem_we;
   logic [8:0]  mem_addr;
   logic [31:0] mem_wdata, mem_rdata;

   logic        ld_we;
   logic [8:0]  ld_addr;
   logic [31:0] ld_data;
   bit   [31:0] mem [DEPTH];

   int nchk = 0;
   int nfail = 0;

   always #5 clk = ~clk;

   fop_core u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .entry(entry_i),
      .busy(busy), .done(done), .fault(fault),
      .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
   );

   always @(posedge clk) begin
      if (ld_we)  mem[ld_addr] <= ld_data;
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
   end

   // reference model state
   bit   [31:0] mmem [DEPTH];
   logic [31:0] macc = '0, ma = '0, mb = '0;
   logic [31:0] exp_wa[$], exp_wd[$];
   int pc = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int addr, input logic [31:0] w);
      ld_we = 1'b1; ld_addr = 9'(addr); ld_data = w;
      mmem[addr] = w;
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   task automatic emit(input logic [7:0] op, input int imm);
      wr(pc, {op, 24'(imm)});
      pc++;
   endtask

   task automatic binop(input logic [7:0] op, input int x, input int y);
      emit(8'h04, y); emit(8'h01, 0); emit(8'h04, x); emit(op, 0);
   endtask

   task automatic store_acc(input int addr);
      emit(8'h02, 0); emit(8'h04, addr); emit(8'h01, 0); emit(8'h03, 0);
      emit(8'h04, 0); emit(8'h11, 0); emit(8'h03, 0); emit(8'h06, 0);
   endtask

   task automatic model_run(input int entry, output int cyc, output bit flt);
      int ip;
      logic [31:0] w, t;
      logic [7:0] op;
      int imm;
      ip = entry; cyc = 0; flt = 0;
      forever begin
         if (ip >= DEPTH) begin cyc += 1; flt = 1; break; end
         w = mmem[ip]; op = w[31:24]; imm = int'(w[23:0]);
         cyc += 2;
         if (op == 8'h00) break;
         if (op == 8'h20 || op == 8'h21) begin
            if (imm == 0) begin flt = 1; break; end
            if (op == 8'h20 || ma == 0) ip += imm; else ip += 1;
            continue;
         end
         case (op)
            8'h01: ma = macc;
            8'h02: mb = macc;
            8'h03: begin t = ma; ma = mb; mb = t; end
            8'h04: macc = 32'(imm);
            8'h05: begin macc = mmem[ma[8:0]]; cyc += 1; end
            8'h06: begin
               mmem[ma[8:0]] = macc;
               exp_wa.push_back({23'd0, ma[8:0]});
               exp_wd.push_back(macc);
            end
            8'h10: macc = macc & ma;
            8'h11: macc = macc | ma;
            8'h12: macc = ~macc;
            8'h13: macc = macc << ma;
            8'h14: macc = macc >> ma;
            8'h15: macc = $unsigned($signed(macc) >>> ma);
            8'h16: macc = macc + ma;
            8'h17: macc = macc - ma;
            8'h18: macc = macc * ma;
            8'h19: begin
               if (ma == 0) begin flt = 1; break; end
               macc = macc / ma;
            end
            default: begin flt = 1; break; end
         endcase
         ip += 1;
      end
   endtask

   task automatic run(input int entry, input string tag, input bit glitch);
      int ecyc, cyc;
      bit eflt;
      logic [31:0] wa, wd;
      model_run(entry, ecyc, eflt);
      start = 1'b1; entry_i = 9'(entry);
      @(negedge clk);
      start = 1'b0;
      chk(busy && mem_re && mem_addr == 9'(entry), "R2", "first fetch at entry",
          {22'd0, busy, mem_addr}, {22'd0, 1'b1, 9'(entry)});
      chk(fault == 1'b0, "R13", "fault cleared by start", 32'(fault), 0);
      cyc = 0;
      while (busy && cyc < 5000) begin
         cyc++;
         if (mem_we) begin
            if (exp_wa.size() == 0) chk(0, "R5", "unexpected write", {23'd0, mem_addr}, 0);
            else begin
               wa = exp_wa.pop_front(); wd = exp_wd.pop_front();
               chk(mem_addr == wa[8:0], "R5", "store address", {23'd0, mem_addr}, wa);
               chk(mem_wdata == wd, tag, "store data", mem_wdata, wd);
            end
         end
         start = glitch && cyc == 3;
         entry_i = '0;
         @(negedge clk);
      end
      start = 1'b0;
      chk(cyc == ecyc, "R3", "busy cycles", cyc, ecyc);
      chk(done == 1'b1, "R11", "done after run", 32'(done), 1);
      chk(fault == eflt, tag, "fault at end", 32'(fault), 32'(eflt));
      chk(exp_wa.size() == 0, "R5", "missing stores", exp_wa.size(), 0);
      exp_wa.delete(); exp_wd.delete();
      @(negedge clk);
      chk(done == 1'b0, "R11", "done single cycle", 32'(done), 0);
      chk(fault == eflt, "R13", "fault held", 32'(fault), 32'(eflt));
      chk(!mem_re && !mem_we, "R1", "quiet when idle", {30'd0, mem_re, mem_we}, 0);
   endtask

   initial begin
      #(200000 * 10);
      nfail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      int e_alu, e_mem, e_div, e_acc, e_j0, e_jz0, e_und, e_far;
      rst_n = 1'b0; start = 1'b0; entry_i = '0; ld_we = 1'b0; ld_addr = '0; ld_data = '0;
      repeat (3) @(negedge clk);
      chk({busy, done, fault, mem_re, mem_we} == 5'b0, "R1", "outputs in reset",
          {27'd0, busy, done, fault, mem_re, mem_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({busy, done, fault, mem_re, mem_we} == 5'b0, "R1", "outputs after reset",
          {27'd0, busy, done, fault, mem_re, mem_we}, 0);

      // R6 R7 R4: arithmetic, logic and shifts
      e_alu = pc;
      binop(8'h16, 1000, 234);        store_acc(400);
      binop(8'h17, 5, 9);             store_acc(401);
      binop(8'h18, 70000, 70000);     store_acc(402);
      binop(8'h19, 1000, 7);          store_acc(403);
      binop(8'h10, 'hF0F0F0, 'h3C3C3C); store_acc(404);
      binop(8'h11, 'hF0F0F0, 'h0F0F01); store_acc(405);
      emit(8'h04, 'h123456); emit(8'h12, 0); store_acc(406);
      binop(8'h13, 'hABCDEF, 12);     store_acc(407);
      binop(8'h13, 1, 31);            store_acc(408);
      emit(8'h04, 4); emit(8'h01, 0); emit(8'h03, 0); emit(8'h04, 0);
      emit(8'h11, 0); emit(8'h03, 0); emit(8'h15, 0); store_acc(409);
      binop(8'h14, 'hFFFFFF, 40);     store_acc(410);
      binop(8'h14, 'hFF0000, 8);      store_acc(411);
      emit(8'h00, 0);
      @(negedge clk);
      run(e_alu, "R6", 0);

      // R5 R8: memory access and forward jumps
      e_mem = pc;
      emit(8'h04, 'h55AA); store_acc(420);
      emit(8'h04, 420); emit(8'h01, 0); emit(8'h05, 0); emit(8'h16, 0); store_acc(421);
      emit(8'h04, 420 + 3 * 512); emit(8'h01, 0); emit(8'h05, 0); store_acc(422);
      emit(8'h20, 2); emit(8'h04, 'hBAD); store_acc(423);
      emit(8'h04, 0); emit(8'h01, 0); emit(8'h21, 2); emit(8'h04, 'hBAD);
      emit(8'h04, 7); store_acc(424);
      emit(8'h04, 3); emit(8'h01, 0); emit(8'h21, 5); emit(8'h04, 'h66); store_acc(425);
      emit(8'h00, 0);
      @(negedge clk);
      run(e_mem, "R8", 0);

      // R2: start while busy is ignored
      run(e_mem, "R2", 1);

      // R10: divide by zero, then read acc back
      e_div = pc;
      emit(8'h04, 0); emit(8'h01, 0); emit(8'h04, 77); emit(8'h19, 0); emit(8'h00, 0);
      e_acc = pc;
      store_acc(430); emit(8'h00, 0);
      // R9: zero offsets
      e_j0 = pc;
      emit(8'h20, 0);
      e_jz0 = pc;
      emit(8'h04, 5); emit(8'h01, 0); emit(8'h21, 0);
      // R10: undefined opcode
      e_und = pc;
      emit(8'h7F, 0);
      // R12: jump far past the end
      e_far = pc;
      emit(8'h20, 'hFFFFFF);
      // R12: step past the last word
      wr(510, {8'h04, 24'd9});
      wr(511, {8'h01, 24'd0});
      @(negedge clk);
      run(e_div, "R10", 0);
      run(e_acc, "R10", 0);
      run(e_j0, "R9", 0);
      run(e_jz0, "R9", 0);
      run(e_und, "R10", 0);
      run(e_far, "R12", 0);
      run(510, "R12", 0);
      run(e_acc, "R13", 0);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end
endmodule